// File: doc/BRIEF.md
# I2C Register Target with Default Read Pointer

This block is an I2C target that fronts a 16-entry byte register file. It finds Start, Repeated Start and Stop conditions on oversampled SCL and SDA inputs. It answers its own 7-bit bus address and treats the first byte of a write transaction as a register pointer. Any bytes that follow are written into the file, and read transactions return bytes from the file. The pointer steps forward after every byte moved and wraps from the last entry back to entry 0.

The last register holds the configuration. Bit 7 is a polling-mode enable and bits 3:0 name a default register. When polling mode is on, the read pointer is reloaded with the default register on each Stop and whenever the target is addressed for reading. A host that only wants to watch one register can then issue a bare read: Start, address with the read bit, data byte, Stop. It skips the address-write byte and the pointer byte that a standard read needs, which makes it two bytes shorter. When polling mode is off, the block is a plain register target whose pointer survives Stop conditions.

Top module: `i2c_dptr_target`

## Requirements
- R1: After reset all 16 registers hold 0x00, the pointer is 0 and SDA is released (sda_oe = 0).
- R2: The target acknowledges only its own address 0x48 (7 bits, followed by the R/W bit, 1 = read). Other addresses get no acknowledge, and bytes sent in those transactions change no register.
- R3: In a write to the target, the first data byte loads the pointer from its bits 3:0. Every later byte is stored at the pointer. All these bytes are acknowledged.
- R4: The pointer increments after each byte read or written and wraps from 15 to 0.
- R5: Register 15 is the configuration register: bit 7 enables polling mode and bits 3:0 give the default register.
- R6: With polling mode off, a Stop leaves the pointer unchanged.
- R7: With polling mode on, every Stop loads the pointer with the default register, so a bare read returns that register.
- R8: With polling mode on, an address match in the read direction loads the default register, whether it follows a Start or a Repeated Start, and even if a pointer byte was just written.
- R9: Read data goes out MSB first. A host NACK after a byte ends the read and SDA stays released until the next Start.
- R10: A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high. The target asserts sda_oe only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions check four things on every cycle. SDA is never newly pulled while the synchronized SCL is high. A Stop either reloads the pointer with the default register or leaves it untouched, depending on the enable bit. SDA is released whenever the target is idle. A register write happens only at the acknowledge of a data byte. The bench scenarios show the rest, because it depends on byte content over whole transactions. That covers which register a bare read or a read after a Repeated Start returns, pointer wrap across a multi-byte read or write, rejection of a foreign address, and the switch from polling mode back to standard behaviour.

// File: rtl/i2c_dptr_pkg.sv
// Shared types for the default-pointer I2C target.
// Assumes: one byte-level engine per target instance.
package i2c_dptr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed, waiting for a Start
        ST_ADDR,   // shifting in the address byte
        ST_ACK,    // target drives the acknowledge bit
        ST_WR,     // shifting in a data byte from the host
        ST_RD,     // shifting out a data byte to the host
        ST_RACK    // host acknowledge slot after a read byte
    } tgt_state_e;
endpackage

// File: rtl/i2c_dptr_sync.sv
// Two-flop synchronizer for SCL/SDA plus edge and bus-condition detection.
// Assumes: clk is several times faster than SCL, so each bus event spans
// multiple samples. All outputs are single-cycle pulses except scl_s/sda_s.
module i2c_dptr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_m, sda_m;
    logic       scl_d, sda_d;

    // Purpose: bring the lines into clk domain and keep one previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_m <= 2'b11;
            sda_m <= 2'b11;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_m <= {scl_m[0], scl_in};
            sda_m <= {sda_m[0], sda_in};
            scl_d <= scl_m[1];
            sda_d <= sda_m[1];
        end
    end

    assign scl_s = scl_m[1];
    assign sda_s = sda_m[1];

    // Purpose: decode clock edges and Start/Stop from current and previous samples.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2c_dptr_regs.sv
// Byte register file with one write port and one read port.
// The last entry is the configuration: bit 7 enables polling mode and the
// low AW bits give the default register. Assumes writes are single-cycle pulses.
module i2c_dptr_regs #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata,
    output logic          mode_en,
    output logic [AW-1:0] dflt_ptr
);
    localparam int DEPTH = 1 << AW;
    localparam int CFG_IDX = DEPTH - 1;

    logic [7:0] regs [DEPTH];

    // Purpose: clear on reset, store one byte per write pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    // Purpose: asynchronous read at the pointer and decode of the configuration entry.
    always_comb begin
        rdata    = regs[raddr];
        mode_en  = regs[CFG_IDX][7];
        dflt_ptr = regs[CFG_IDX][AW-1:0];
    end
endmodule

// File: rtl/i2c_dptr_engine.sv
// Byte-level protocol engine: address match, ACK/NACK, shifting, pointer.
// Assumes: inputs come from i2c_dptr_sync; SDA is changed only on an SCL
// falling-edge pulse (or released on Start/Stop); the pointer reloads with
// the default on Stop and on a read-direction address match when enabled.
module i2c_dptr_engine
    import i2c_dptr_pkg::*;
#(
    parameter int          AW       = 4,
    parameter logic [6:0]  TGT_ADDR = 7'h48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [7:0]    rdata,
    input  logic          mode_en,
    input  logic [AW-1:0] dflt_ptr,
    output logic          sda_oe,
    output logic [AW-1:0] ptr,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [7:0]    wdata,
    output tgt_state_e    state
);
    logic [2:0] bcnt;
    logic [7:0] sh;
    logic [6:0] tx;
    logic       got8, rw, ptr_phase, nack;

    // Purpose: the whole transaction state machine, one bus event per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; sda_oe <= 1'b0; ptr <= '0; we <= 1'b0;
            waddr <= '0; wdata <= '0; bcnt <= '0; sh <= '0; tx <= '0;
            got8 <= 1'b0; rw <= 1'b0; ptr_phase <= 1'b0; nack <= 1'b0;
        end else begin
            we <= 1'b0;
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                if (mode_en) ptr <= dflt_ptr;
            end else if (start_det) begin
                state  <= ST_ADDR;
                sda_oe <= 1'b0;
                bcnt   <= '0;
                got8   <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise) begin
                            sh   <= {sh[6:0], sda_s};
                            bcnt <= bcnt + 3'd1;
                            got8 <= (bcnt == 3'd7);
                        end else if (scl_fall && got8) begin
                            got8 <= 1'b0;
                            if (state == ST_ADDR) begin
                                if (sh[7:1] == TGT_ADDR) begin
                                    sda_oe    <= 1'b1;
                                    rw        <= sh[0];
                                    ptr_phase <= ~sh[0];
                                    state     <= ST_ACK;
                                    if (sh[0] && mode_en) ptr <= dflt_ptr;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                                if (ptr_phase) begin
                                    ptr       <= sh[AW-1:0];
                                    ptr_phase <= 1'b0;
                                end else begin
                                    we    <= 1'b1;
                                    waddr <= ptr;
                                    wdata <= sh;
                                    ptr   <= ptr + 1'b1;
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bcnt <= '0;
                            if (rw) begin
                                tx     <= rdata[6:0];
                                sda_oe <= ~rdata[7];
                                state  <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WR;
                            end
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            bcnt <= bcnt + 3'd1;
                            if (bcnt == 3'd7) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 1'b1;
                                state  <= ST_RACK;
                            end else begin
                                sda_oe <= ~tx[6];
                                tx     <= {tx[5:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            nack <= sda_s;
                        end else if (scl_fall) begin
                            if (nack) begin
                                state <= ST_IDLE;
                            end else begin
                                tx     <= rdata[6:0];
                                sda_oe <= ~rdata[7];
                                bcnt   <= '0;
                                state  <= ST_RD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_dptr_target.sv
// Top: I2C target over a 2**AW byte register file with a polling-mode
// default read pointer. Assumes an external open-drain pad: sda_oe = 1 pulls low.
module i2c_dptr_target
    import i2c_dptr_pkg::*;
#(
    parameter int         AW       = 4,
    parameter logic [6:0] TGT_ADDR = 7'h48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          we, mode_en;
    logic [AW-1:0] ptr, waddr, dflt_ptr;
    logic [7:0]    wdata, rdata;
    tgt_state_e    state;

    i2c_dptr_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_dptr_engine #(.AW(AW), .TGT_ADDR(TGT_ADDR)) u_eng (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rdata(rdata), .mode_en(mode_en), .dflt_ptr(dflt_ptr),
        .sda_oe(sda_oe), .ptr(ptr), .we(we), .waddr(waddr), .wdata(wdata),
        .state(state)
    );

    i2c_dptr_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(ptr), .rdata(rdata), .mode_en(mode_en), .dflt_ptr(dflt_ptr)
    );
endmodule

// File: rtl/i2c_dptr_checker.sv
// Cycle-level properties of the default-pointer target, bound into the top.
// Assumes the signal names of i2c_dptr_target.
module i2c_dptr_checker
    import i2c_dptr_pkg::*;
#(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          stop_det,
    input logic          sda_oe,
    input logic          mode_en,
    input logic          we,
    input logic [AW-1:0] ptr,
    input logic [AW-1:0] dflt_ptr,
    input tgt_state_e    state
);
    AST_OE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);                                          // R10
    AST_STOP_LOADS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && mode_en) |=> (ptr == $past(dflt_ptr)));                // R7
    AST_STOP_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !mode_en) |=> (ptr == $past(ptr)));                    // R6
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);                                    // R9
    AST_WRITE_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (state == ST_ACK && sda_oe));                                // R3
endmodule

bind i2c_dptr_target i2c_dptr_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
    .sda_oe(sda_oe), .mode_en(mode_en), .we(we), .ptr(ptr),
    .dflt_ptr(dflt_ptr), .state(state)
);

// File: tb/tb_i2c_dptr_target.sv
`timescale 1ns/1ps
module tb_i2c_dptr_target;
    localparam int QTR = 10;
    localparam logic [6:0] ME = 7'h48;
    localparam int NV = 14;
    // {op, reg, data}: op 0 write, 1 standard read, 2 bare read, 3 standard read in polling mode
    localparam logic [13:0] VEC [NV] = '{
        {2'd0, 4'd3,  8'hA5}, {2'd0, 4'd4,  8'h3C},
        {2'd1, 4'd3,  8'hA5}, {2'd1, 4'd4,  8'h3C},
        {2'd0, 4'd15, 8'h83}, {2'd2, 4'd0,  8'hA5},
        {2'd0, 4'd4,  8'h77}, {2'd2, 4'd0,  8'hA5},
        {2'd3, 4'd4,  8'hA5}, {2'd0, 4'd15, 8'h04},
        {2'd2, 4'd0,  8'h00}, {2'd0, 4'd5,  8'h5A},
        {2'd1, 4'd4,  8'h77}, {2'd2, 4'd0,  8'h5A}
    };

    logic clk = 1'b0, rst_n = 1'b0, scl_h = 1'b1, sda_h = 1'b1;
    logic sda_oe, sda_bus;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;
    assign sda_bus = sda_h & ~sda_oe;

    i2c_dptr_target dut (.clk(clk), .rst_n(rst_n), .scl_in(scl_h),
                         .sda_in(sda_bus), .sda_oe(sda_oe));

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic q(); repeat (QTR) @(posedge clk); #1; endtask
    task automatic bit_out(input logic b);
        sda_h = b; q(); scl_h = 1'b1; q(); q(); scl_h = 1'b0; q();
    endtask
    task automatic bit_in(output logic b);
        sda_h = 1'b1; q(); scl_h = 1'b1; q(); b = sda_bus; q(); scl_h = 1'b0; q();
    endtask
    task automatic start();
        sda_h = 1'b1; q(); scl_h = 1'b1; q(); sda_h = 1'b0; q(); scl_h = 1'b0; q();
    endtask
    task automatic stop();
        sda_h = 1'b0; q(); scl_h = 1'b1; q(); sda_h = 1'b1; q(); q();
    endtask
    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(ack);
    endtask
    task automatic rbyte(input logic nk, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) bit_in(b[i]);
        bit_out(nk);
    endtask

    task automatic wr_reg(input logic [3:0] r, input logic [7:0] d);
        logic a;
        start(); wbyte({ME, 1'b0}, a); chk("R2 addr ack", {7'd0, a}, 8'd0);
        wbyte({4'd0, r}, a); chk("R3 ptr ack", {7'd0, a}, 8'd0);
        wbyte(d, a); chk("R3 data ack", {7'd0, a}, 8'd0);
        stop();
    endtask
    task automatic std_rd(input string tag, input logic [3:0] r, input logic [7:0] e);
        logic a; logic [7:0] b;
        start(); wbyte({ME, 1'b0}, a); wbyte({4'd0, r}, a);
        start(); wbyte({ME, 1'b1}, a); rbyte(1'b1, b); stop();
        chk(tag, b, e);
    endtask
    task automatic bare_rd(input string tag, input logic [7:0] e);
        logic a; logic [7:0] b;
        start(); wbyte({ME, 1'b1}, a); rbyte(1'b1, b); stop();
        chk(tag, b, e);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R1 watchdog: actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic a; logic [7:0] b0, b1;
        repeat (5) @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (3) @(posedge clk); #1;
        chk("R1 sda released after reset", {7'd0, sda_oe}, 8'd0);
        bare_rd("R1 reset pointer and data", 8'h00);

        // table of register traffic, polling mode toggled by writes to register 15 (R5)
        for (int v = 0; v < NV; v++) begin
            case (VEC[v][13:12])
                2'd0: wr_reg(VEC[v][11:8], VEC[v][7:0]);
                2'd1: std_rd("R3 standard read", VEC[v][11:8], VEC[v][7:0]);
                2'd2: bare_rd((v == 10) ? "R4 wrap then R6 hold" :
                              (v == 13) ? "R6 pointer kept over stop" :
                                          "R7 bare read default", VEC[v][7:0]);
                default: std_rd("R8 read after pointer write", VEC[v][11:8], VEC[v][7:0]);
            endcase
        end

        // foreign address: NACK and no register change
        start(); wbyte({7'h11, 1'b0}, a);
        chk("R2 foreign address nack", {7'd0, a}, 8'd1);
        wbyte(8'h03, a); wbyte(8'hFF, a); stop();
        std_rd("R2 foreign write ignored", 4'd3, 8'hA5);

        // multi-byte write with auto-increment
        start(); wbyte({ME, 1'b0}, a); wbyte(8'h08, a); wbyte(8'h11, a);
        wbyte(8'h22, a); stop();
        std_rd("R4 write increment", 4'd9, 8'h22);

        // multi-byte read across the wrap point, then NACK release
        start(); wbyte({ME, 1'b0}, a); wbyte(8'h0F, a);
        start(); wbyte({ME, 1'b1}, a); rbyte(1'b0, b0); rbyte(1'b1, b1);
        chk("R9 sda released after nack", {7'd0, sda_oe}, 8'd0);
        stop();
        chk("R5 config readback", b0, 8'h04);
        chk("R4 read wraps to register 0", b1, 8'h00);

        // polling mode, default register 5: read, repeated start, read again
        wr_reg(4'd15, 8'h85);
        start(); wbyte({ME, 1'b1}, a); rbyte(1'b0, b0); rbyte(1'b1, b1);
        chk("R9 first byte MSB first", b0, 8'h5A);
        chk("R4 second byte register 6", b1, 8'h00);
        start(); wbyte({ME, 1'b1}, a); rbyte(1'b1, b0); stop();
        chk("R8 repeated start returns default", b0, 8'h5A);

        summary();
        $finish;
    end
endmodule